// File: doc/BRIEF.md
# Processor Low-Power Pin Sequencer

This block sits in system logic and owns the four active-low control lines that move a processor between its running, clock-stopped, sleeping and deep-sleeping conditions, plus its hardware reset line. Firmware or a power manager raises single-cycle requests: stop the clock, sleep, deep sleep, wake, or reset. The block turns each request into a series of pin edges that always respects the legal ordering between the lines and the minimum spacing each edge needs. Spacing is counted in bus clocks, and the reset interval is derived from a clock-frequency parameter.

Two inputs come from the processor side. An active-low break-event line is treated as a wake request while the processor is clock-stopped. A bus-idle flag gates entry into sleep, so that the clock stops only when no snoop traffic is in flight. A level `busy` marks multi-cycle sequences. A one-cycle `seq_done` marks the end of every sequence that completes.

Top module: `lowpwr_pin_sequencer`

## Requirements
- R1: After `rst_n` is released, `clk_stop_n`, `sleep_n`, `deep_sleep_n` and `cpu_reset_n` are all 1 (deasserted), and `busy` and `seq_done` are 0.
- R2: In the running condition (all pins 1), a `req_stop_grant` pulse drives `clk_stop_n` to 0 on the next clock edge, with `seq_done` high for that cycle. The request is ignored in any other condition.
- R3: `sleep_n` falls only when `clk_stop_n` was already 0 in the cycle before. `req_sleep` is honoured only in the clock-stopped condition. If `bus_idle` is 0, the block goes busy and drives `sleep_n` to 0 on the first edge that sees `bus_idle` at 1.
- R4: `deep_sleep_n` is 0 only while `sleep_n` is 0. `req_deep_sleep` is honoured only in the sleeping condition, and drives `deep_sleep_n` low on the next edge.
- R5: `req_wake` returns the processor to running. From clock-stopped, `clk_stop_n` rises on the next edge. From deep sleep, `deep_sleep_n` rises first and `sleep_n` rises one edge later. From sleep, `sleep_n` rises on the next edge. In both sleep cases, `clk_stop_n` rises exactly `SLP_GAP_CLKS` edges after `sleep_n` rose.
- R6: While clock-stopped and not busy, `brk_evt_n` at 0 acts as a wake request: `clk_stop_n` rises on the next edge. In any other condition it has no effect.
- R7: A `req_cpu_reset` pulse drives `cpu_reset_n` to 0 on the next edge, in any condition and even while busy. On the edge after that, `clk_stop_n`, `sleep_n` and `deep_sleep_n` are all driven to 1.
- R8: `cpu_reset_n` rises no earlier than `floor(CLK_HZ*RESET_GAP_US/1e6)+1` edges after the three sleep lines were released, and not while `req_cpu_reset` is still 1. It rises on the first edge at which both conditions hold.
- R9: While `busy` is 1, every request other than reset is ignored, including a break event and a wake.
- R10: `seq_done` is a single-cycle pulse raised on the edge that completes a sequence, and it is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| req_stop_grant | input | 1 | Request: stop the processor clock |
| req_sleep | input | 1 | Request: enter sleep |
| req_deep_sleep | input | 1 | Request: enter deep sleep |
| req_wake | input | 1 | Request: return to running |
| req_cpu_reset | input | 1 | Request: reset the processor; holding it extends the reset |
| brk_evt_n | input | 1 | Active-low pending-event indication from the processor |
| bus_idle | input | 1 | High when no snoop traffic is in flight |
| clk_stop_n | output | 1 | Active-low clock-stop request to the processor |
| sleep_n | output | 1 | Active-low sleep request to the processor |
| deep_sleep_n | output | 1 | Active-low deep-sleep request to the processor |
| cpu_reset_n | output | 1 | Active-low processor reset |
| busy | output | 1 | A multi-cycle sequence is in progress |
| seq_done | output | 1 | One-cycle pulse at the completion of a sequence |

## Verification
The bench counts the exact edge distance from the release of `sleep_n` to the release of `clk_stop_n`. An off-by-one in the gap timer would show up there as one clock too early or too late. It also counts the distance from the release of the sleep lines to the release of `cpu_reset_n`. A design that timed that interval from the reset request, rather than from the line release, would free the processor one clock early. A wake or break event raised during a stalled sleep entry must have no effect: a design that ignored `busy` would restart the clock in the middle of a sequence. A reset issued in the middle of a wake gap, and a reset held longer than the interval, check that reset preempts busy sequences and that release waits for the request to drop.

// File: rtl/sleepseq_pkg.sv
package sleepseq_pkg;

  typedef enum logic [3:0] {
    ST_NORMAL,
    ST_STOPGNT,
    ST_SLEEP,
    ST_DEEP,
    ST_SLP_WAIT,
    ST_WK_SLP,
    ST_WK_GAP,
    ST_RST_ASSERT,
    ST_RST_HOLD
  } seq_state_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_STOPGNT,
    CMD_SLEEP,
    CMD_DEEP,
    CMD_WAKE,
    CMD_RESET
  } seq_cmd_e;

  typedef struct packed {
    logic clk_stop_n;
    logic sleep_n;
    logic deep_n;
    logic cpu_rst_n;
  } pin_set_t;

  // Clock edges strictly longer than gap_us at clk_hz.
  function automatic int unsigned rst_gap_cycles(input longint unsigned clk_hz,
                                                 input longint unsigned gap_us);
    longint unsigned whole;
    whole = (clk_hz * gap_us) / 64'd1_000_000;
    return int'(whole) + 1;
  endfunction

  // Bits needed to hold any value 0..maxv.
  function automatic int unsigned cnt_width(input int unsigned maxv);
    if (maxv < 2) return 1;
    return $clog2(maxv + 1);
  endfunction

  function automatic logic is_busy(input seq_state_e s);
    return (s == ST_SLP_WAIT) || (s == ST_WK_SLP) || (s == ST_WK_GAP) ||
           (s == ST_RST_ASSERT) || (s == ST_RST_HOLD);
  endfunction

endpackage

// File: rtl/seq_gap_timer.sv
module seq_gap_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/seq_req_arbiter.sv
module seq_req_arbiter
  import sleepseq_pkg::*;
(
  input  seq_state_e state,
  input  logic       req_stop_grant,
  input  logic       req_sleep,
  input  logic       req_deep_sleep,
  input  logic       req_wake,
  input  logic       req_cpu_reset,
  input  logic       brk_evt_n,
  output seq_cmd_e   cmd
);

  logic in_reset;
  logic wake_any;

  always_comb begin
    in_reset = (state == ST_RST_ASSERT) || (state == ST_RST_HOLD);
    wake_any = req_wake || ((state == ST_STOPGNT) && !brk_evt_n);
    cmd      = CMD_NONE;
    if (req_cpu_reset && !in_reset) begin
      cmd = CMD_RESET;
    end else if (!is_busy(state)) begin
      if (wake_any && (state != ST_NORMAL)) begin
        cmd = CMD_WAKE;
      end else if (req_stop_grant && (state == ST_NORMAL)) begin
        cmd = CMD_STOPGNT;
      end else if (req_sleep && (state == ST_STOPGNT)) begin
        cmd = CMD_SLEEP;
      end else if (req_deep_sleep && (state == ST_SLEEP)) begin
        cmd = CMD_DEEP;
      end
    end
  end

endmodule

// File: rtl/seq_pin_fsm.sv
module seq_pin_fsm
  import sleepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_cmd_e   cmd,
  input  logic       bus_idle,
  input  logic       req_cpu_reset,
  input  logic       slp_gap_done,
  input  logic       rst_gap_done,
  output seq_state_e state,
  output pin_set_t   pins,
  output logic       done,
  output logic       slp_gap_load,
  output logic       rst_gap_load
);

  seq_state_e state_q;
  pin_set_t   pins_q;
  logic       done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      pins_q  <= '{clk_stop_n: 1'b1, sleep_n: 1'b1, deep_n: 1'b1, cpu_rst_n: 1'b1};
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cmd == CMD_RESET) begin
        pins_q.cpu_rst_n <= 1'b0;
        state_q          <= ST_RST_ASSERT;
      end else begin
        case (state_q)
          ST_NORMAL: begin
            if (cmd == CMD_STOPGNT) begin
              pins_q.clk_stop_n <= 1'b0;
              state_q           <= ST_STOPGNT;
              done_q            <= 1'b1;
            end
          end
          ST_STOPGNT: begin
            if (cmd == CMD_WAKE) begin
              pins_q.clk_stop_n <= 1'b1;
              state_q           <= ST_NORMAL;
              done_q            <= 1'b1;
            end else if (cmd == CMD_SLEEP) begin
              if (bus_idle) begin
                pins_q.sleep_n <= 1'b0;
                state_q        <= ST_SLEEP;
                done_q         <= 1'b1;
              end else begin
                state_q <= ST_SLP_WAIT;
              end
            end
          end
          ST_SLP_WAIT: begin
            if (bus_idle) begin
              pins_q.sleep_n <= 1'b0;
              state_q        <= ST_SLEEP;
              done_q         <= 1'b1;
            end
          end
          ST_SLEEP: begin
            if (cmd == CMD_DEEP) begin
              pins_q.deep_n <= 1'b0;
              state_q       <= ST_DEEP;
              done_q        <= 1'b1;
            end else if (cmd == CMD_WAKE) begin
              pins_q.sleep_n <= 1'b1;
              state_q        <= ST_WK_GAP;
            end
          end
          ST_DEEP: begin
            if (cmd == CMD_WAKE) begin
              pins_q.deep_n <= 1'b1;
              state_q       <= ST_WK_SLP;
            end
          end
          ST_WK_SLP: begin
            pins_q.sleep_n <= 1'b1;
            state_q        <= ST_WK_GAP;
          end
          ST_WK_GAP: begin
            if (slp_gap_done) begin
              pins_q.clk_stop_n <= 1'b1;
              state_q           <= ST_NORMAL;
              done_q            <= 1'b1;
            end
          end
          ST_RST_ASSERT: begin
            pins_q.clk_stop_n <= 1'b1;
            pins_q.sleep_n    <= 1'b1;
            pins_q.deep_n     <= 1'b1;
            state_q           <= ST_RST_HOLD;
          end
          ST_RST_HOLD: begin
            if (rst_gap_done && !req_cpu_reset) begin
              pins_q.cpu_rst_n <= 1'b1;
              state_q          <= ST_NORMAL;
              done_q           <= 1'b1;
            end
          end
          default: state_q <= ST_NORMAL;
        endcase
      end
    end
  end

  // Timers are armed on the same edge that releases the line they time from.
  assign slp_gap_load = (state_q == ST_WK_SLP) ||
                        ((state_q == ST_SLEEP) && (cmd == CMD_WAKE));
  assign rst_gap_load = (state_q == ST_RST_ASSERT);
  assign state        = state_q;
  assign pins         = pins_q;
  assign done         = done_q;

endmodule

// File: rtl/lowpwr_pin_sequencer.sv
module lowpwr_pin_sequencer
  import sleepseq_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned RESET_GAP_US = 480,
  parameter int unsigned SLP_GAP_CLKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_stop_grant,
  input  logic req_sleep,
  input  logic req_deep_sleep,
  input  logic req_wake,
  input  logic req_cpu_reset,
  input  logic brk_evt_n,
  input  logic bus_idle,
  output logic clk_stop_n,
  output logic sleep_n,
  output logic deep_sleep_n,
  output logic cpu_reset_n,
  output logic busy,
  output logic seq_done
);

  localparam int unsigned RST_GAP_CYC = rst_gap_cycles(longint'(CLK_HZ), longint'(RESET_GAP_US));
  localparam int unsigned RST_W       = cnt_width(RST_GAP_CYC);
  localparam int unsigned SLP_W       = cnt_width(SLP_GAP_CLKS);
  localparam logic [RST_W-1:0] RST_LOAD = RST_W'(RST_GAP_CYC - 1);
  localparam logic [SLP_W-1:0] SLP_LOAD = SLP_W'(SLP_GAP_CLKS - 1);

  seq_state_e fsm_state;
  seq_cmd_e   arb_cmd;
  pin_set_t   pin_bus;
  logic       slp_gap_done;
  logic       rst_gap_done;
  logic       slp_gap_load;
  logic       rst_gap_load;
  logic       done_evt;

  seq_req_arbiter u_arb (
    .state          (fsm_state),
    .req_stop_grant (req_stop_grant),
    .req_sleep      (req_sleep),
    .req_deep_sleep (req_deep_sleep),
    .req_wake       (req_wake),
    .req_cpu_reset  (req_cpu_reset),
    .brk_evt_n      (brk_evt_n),
    .cmd            (arb_cmd)
  );

  seq_pin_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd           (arb_cmd),
    .bus_idle      (bus_idle),
    .req_cpu_reset (req_cpu_reset),
    .slp_gap_done  (slp_gap_done),
    .rst_gap_done  (rst_gap_done),
    .state         (fsm_state),
    .pins          (pin_bus),
    .done          (done_evt),
    .slp_gap_load  (slp_gap_load),
    .rst_gap_load  (rst_gap_load)
  );

  seq_gap_timer #(.W(SLP_W)) u_slp_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (slp_gap_load),
    .load_val (SLP_LOAD),
    .expired  (slp_gap_done)
  );

  seq_gap_timer #(.W(RST_W)) u_rst_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rst_gap_load),
    .load_val (RST_LOAD),
    .expired  (rst_gap_done)
  );

  assign clk_stop_n   = pin_bus.clk_stop_n;
  assign sleep_n      = pin_bus.sleep_n;
  assign deep_sleep_n = pin_bus.deep_n;
  assign cpu_reset_n  = pin_bus.cpu_rst_n;
  assign busy         = is_busy(fsm_state);
  assign seq_done     = done_evt;

endmodule

// File: rtl/lowpwr_pin_sequencer_chk.sv
module lowpwr_pin_sequencer_chk
  import sleepseq_pkg::*;
#(
  parameter int unsigned RST_GAP_CYC  = 481,
  parameter int unsigned SLP_GAP_CLKS = 10
) (
  input logic     clk,
  input logic     rst_n,
  input logic     clk_stop_n,
  input logic     sleep_n,
  input logic     deep_sleep_n,
  input logic     cpu_reset_n,
  input logic     busy,
  input logic     seq_done,
  input seq_cmd_e arb_cmd
);

  localparam int unsigned RW = cnt_width(RST_GAP_CYC);
  localparam int unsigned SW = cnt_width(SLP_GAP_CLKS);

  logic [SW-1:0] since_slp;
  logic [RW-1:0] since_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_slp <= SW'(SLP_GAP_CLKS);
      since_rel <= '0;
    end else begin
      if (!sleep_n) since_slp <= '0;
      else if (since_slp < SW'(SLP_GAP_CLKS)) since_slp <= since_slp + 1'b1;
      if (!clk_stop_n || !sleep_n || !deep_sleep_n) since_rel <= '0;
      else if (since_rel < RW'(RST_GAP_CYC)) since_rel <= since_rel + 1'b1;
    end
  end

  AST_SLEEP_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |-> !clk_stop_n);                                                  // R3
  AST_SLEEP_ENTRY_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_n) |-> $past(!clk_stop_n));                                     // R3
  AST_DEEP_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !deep_sleep_n |-> !sleep_n);                                                // R4
  AST_WAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_stop_n) && cpu_reset_n) |-> (since_slp >= SW'(SLP_GAP_CLKS)));   // R5
  AST_RESET_DROPS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_reset_n) |=> (clk_stop_n && sleep_n && deep_sleep_n));           // R7
  AST_RESET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_reset_n) |-> (since_rel >= RW'(RST_GAP_CYC)));                    // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (arb_cmd == CMD_NONE || arb_cmd == CMD_RESET));                   // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !busy);                                                        // R10

endmodule

bind lowpwr_pin_sequencer lowpwr_pin_sequencer_chk #(
  .RST_GAP_CYC  (RST_GAP_CYC),
  .SLP_GAP_CLKS (SLP_GAP_CLKS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_stop_n   (clk_stop_n),
  .sleep_n      (sleep_n),
  .deep_sleep_n (deep_sleep_n),
  .cpu_reset_n  (cpu_reset_n),
  .busy         (busy),
  .seq_done     (seq_done),
  .arb_cmd      (arb_cmd)
);

// File: tb/lowpwr_pin_sequencer_tb.sv
module lowpwr_pin_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TB_HZ      = 1_000_000;
  localparam int TB_GAP     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_stop_grant = 1'b0, req_sleep = 1'b0, req_deep_sleep = 1'b0;
  logic req_wake = 1'b0, req_cpu_reset = 1'b0, brk_evt_n = 1'b1, bus_idle = 1'b1;
  logic clk_stop_n, sleep_n, deep_sleep_n, cpu_reset_n, busy, seq_done;

  int checks = 0;
  int errors = 0;
  int lvl = 0;      // 0 running, 1 clock-stopped, 2 sleep, 3 deep sleep
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowpwr_pin_sequencer #(.CLK_HZ(TB_HZ), .RESET_GAP_US(480), .SLP_GAP_CLKS(TB_GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_stop_grant(req_stop_grant), .req_sleep(req_sleep),
    .req_deep_sleep(req_deep_sleep), .req_wake(req_wake), .req_cpu_reset(req_cpu_reset),
    .brk_evt_n(brk_evt_n), .bus_idle(bus_idle), .clk_stop_n(clk_stop_n), .sleep_n(sleep_n),
    .deep_sleep_n(deep_sleep_n), .cpu_reset_n(cpu_reset_n), .busy(busy), .seq_done(seq_done)
  );

  // 480 us in whole microsecond ticks, plus one edge to be strictly longer.
  function automatic int exp_rst_gap(input int hz);
    return (hz / 1000) * 480 / 1000 + 1;
  endfunction

  function automatic int exp_pins(input int l);
    return {28'd0, (l == 0), (l < 2), (l < 3), 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pins_match(input string tag);
    int act;
    act = {28'd0, clk_stop_n, sleep_n, deep_sleep_n, cpu_reset_n};
    chk(act == exp_pins(lvl), tag, act, exp_pins(lvl));
  endtask

  task automatic drive_req(input int which, input bit v);
    case (which)
      0: req_stop_grant = v;
      1: req_sleep      = v;
      2: req_deep_sleep = v;
      3: req_wake       = v;
      4: brk_evt_n      = !v;
      default: req_cpu_reset = v;
    endcase
  endtask

  task automatic pulse(input int which);
    @(negedge clk) drive_req(which, 1'b1);
    @(negedge clk) drive_req(which, 1'b0);
  endtask

  task automatic wake_seq(input bit from_deep);
    int n;
    if (from_deep) begin
      chk(deep_sleep_n && !sleep_n && busy, "R5 deep released first", deep_sleep_n, 1);
      @(negedge clk);
    end
    chk(sleep_n && !clk_stop_n, "R5 sleep released before clock", clk_stop_n, 0);
    n = 0;
    while (!clk_stop_n && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == TB_GAP, "R5 gap from sleep release", n, TB_GAP);
    chk(seq_done == 1'b1, "R10 done at wake end", seq_done, 1);
    @(negedge clk);
    chk(seq_done == 1'b0, "R10 done lasts one cycle", seq_done, 0);
  endtask

  task automatic reset_seq(input int extra_hold);
    int n;
    @(negedge clk) req_cpu_reset = 1'b1;
    @(negedge clk);
    chk(cpu_reset_n == 1'b0, "R7 reset asserted", cpu_reset_n, 0);
    if (extra_hold == 0) req_cpu_reset = 1'b0;
    @(negedge clk);
    chk(clk_stop_n && sleep_n && deep_sleep_n, "R7 sleep lines released",
        {clk_stop_n, sleep_n, deep_sleep_n}, 7);
    if (extra_hold > 0) begin
      repeat (extra_hold) @(negedge clk);
      chk(cpu_reset_n == 1'b0, "R8 held reset extended", cpu_reset_n, 0);
      req_cpu_reset = 1'b0;
      @(negedge clk);
      chk(cpu_reset_n == 1'b1, "R8 release on request drop", cpu_reset_n, 1);
    end else begin
      n = 0;
      while (!cpu_reset_n && n < 100000) begin
        @(negedge clk);
        n++;
      end
      chk(n == exp_rst_gap(TB_HZ), "R8 reset interval", n, exp_rst_gap(TB_HZ));
    end
    chk(seq_done && !busy, "R10 done at reset end", seq_done, 1);
    lvl = 0;
  endtask

  task automatic do_op(input int op);
    int prev;
    prev = lvl;
    if (op == 5) begin
      reset_seq(0);
      pins_match("R7 pins after reset");
      return;
    end
    pulse(op);
    case (op)
      0: begin
        if (prev == 0) lvl = 1;
        chk(seq_done == (prev == 0), "R2 stop-grant done", seq_done, prev == 0);
        pins_match("R2 pins after stop-grant request");
      end
      1: begin
        if (prev == 1) lvl = 2;
        chk(seq_done == (prev == 1), "R3 sleep done", seq_done, prev == 1);
        pins_match("R3 pins after sleep request");
      end
      2: begin
        if (prev == 2) lvl = 3;
        chk(seq_done == (prev == 2), "R4 deep done", seq_done, prev == 2);
        pins_match("R4 pins after deep request");
      end
      3: begin
        if (prev >= 2) wake_seq(prev == 3);
        else chk(seq_done == (prev == 1), "R5 wake done", seq_done, prev == 1);
        lvl = 0;
        pins_match("R5 pins after wake");
      end
      default: begin
        if (prev == 1) lvl = 0;
        chk(seq_done == (prev == 1), "R6 break event done", seq_done, prev == 1);
        pins_match("R6 pins after break event");
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pins_match("R1 pins after reset");
    chk(!busy && !seq_done, "R1 busy and done idle", {busy, seq_done}, 0);

    // Ignored requests from running, then stop-grant.
    do_op(1); do_op(2); do_op(4);
    do_op(0);

    // Stalled sleep entry: wake and break event ignored while busy.
    @(negedge clk) bus_idle = 1'b0;
    pulse(1);
    chk(sleep_n && busy, "R3 sleep waits for idle bus", sleep_n, 1);
    pulse(3);
    chk(!clk_stop_n && busy, "R9 wake ignored while busy", clk_stop_n, 0);
    pulse(4);
    chk(!clk_stop_n && sleep_n, "R9 break ignored while busy", clk_stop_n, 0);
    bus_idle = 1'b1;
    @(negedge clk);
    chk(!sleep_n && seq_done && !busy, "R3 sleep after bus idle", sleep_n, 0);
    lvl = 2;
    do_op(0);                      // ignored in sleep
    do_op(2);
    do_op(3);                      // wake from deep
    do_op(0);
    do_op(4);                      // break event wake
    do_op(0); do_op(1); do_op(2);
    do_op(5);                      // reset from deep sleep
    do_op(0); do_op(1);
    pulse(3);                      // reset in the middle of a wake gap
    repeat (3) @(negedge clk);
    chk(busy && !clk_stop_n, "R9 still in wake gap", busy, 1);
    reset_seq(0);
    pins_match("R7 pins after reset during wake");
    reset_seq(exp_rst_gap(TB_HZ) + 20);
    pins_match("R8 pins after long reset");

    for (int i = 0; i < 120; i++) begin
      int r;
      int op;
      r = $urandom_range(0, 9);
      case (r)
        0, 1: op = 0;
        2, 3: op = 1;
        4:    op = 2;
        5, 6: op = 3;
        7, 8: op = 4;
        default: op = ($urandom_range(0, 3) == 0) ? 5 : 0;
      endcase
      do_op(op);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 R8 sequence never completed actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule